// File: doc/BRIEF.md
# Selectable-Edge Line Status Interrupt Generator

This block turns per-channel line-status flags into latched interrupt events. Each of two channels carries seven single-bit condition flags: loss of signal, alarm indication signal, driver failure, transmit clock loss, test-pattern (PRBS/QRSS) sync, loopback deactivate-code detect and loopback activate-code detect. The block samples each flag every clock cycle and compares it with the value from the cycle before. A per-source edge-select bit decides whether only a rising transition of the flag is an event, or whether a transition in either direction is an event.

Events set sticky pending bits. Software clears them by writing ones to the pending register. A per-channel enable register masks which pending bits drive the channel's active-high interrupt output. Software reaches the edge-select, pending and enable registers through a simple register port. Writes take effect on the clock edge. Reads return data one cycle after the read strobe. The flags come from line logic outside this block and are taken as synchronous to the clock.

Top module: `line_status_irq`

## Requirements
- R1: Synchronous active-high reset clears every edge-select, pending and enable bit, the previous-flag samples, the interrupt outputs and the read data.
- R2: Channel c uses three registers. Edge-select is at address 0x15 + 0x20*c, pending is at 0x16 + 0x20*c, and enable is at 0x17 + 0x20*c. In each register, source bits are assigned as follows: bit 0 loss of signal, bit 1 alarm indication, bit 2 driver failure, bit 3 transmit clock loss, bit 4 pattern sync, bit 5 loopback deactivate, bit 6 loopback activate. Data asked for with rd_en in one cycle appears on rd_data in the next cycle, and rd_data is 0 in any cycle that follows no read.
- R3: Bit 7 of every register reads as 0, and writes to it are ignored.
- R4: A 0-to-1 change of a flag, relative to its value in the previous cycle, sets the matching pending bit. This holds whatever the edge-select value. The pending bit and the interrupt output can be observed from the cycle after the flag changes.
- R5: When a source's edge-select bit is 0, a 1-to-0 change of its flag sets nothing.
- R6: When a source's edge-select bit is 1, a 1-to-0 change of its flag sets the pending bit.
- R7: Writing a 1 to a pending bit clears it, and writing a 0 leaves it unchanged. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: irq_out[c] is high exactly when some pending bit of channel c has its enable bit set. It updates on the same edge as the pending and enable registers. Disabled sources still latch pending bits.
- R9: Writing an edge-select bit never creates an event by itself. The new select value governs detection only from the cycle after the write, so a falling flag in the cycle of the write is judged by the old value.
- R10: Reads from any address outside the six mapped registers return 0. Events, clears and register writes of one channel leave the other channel untouched.
- R11: A flag held at 1 yields a single event. Once cleared, the pending bit stays clear while the flag stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (8) | Write address |
| wr_data | input | DATA_W (8) | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W (8) | Read address |
| rd_data | output | DATA_W (8) | Read data, valid the cycle after rd_en |
| status_in | input | NUM_CH*NUM_SRC (14) | Status flags; channel c source s at bit c*NUM_SRC+s |
| irq_out | output | NUM_CH (2) | Per-channel active-high interrupt |

## Verification
The bench sweeps every channel, source and select value. For each combination it drives a rise and then a fall of the flag and expects a pending bit after the fall exactly when the select bit is 1. A design that decoded the select bit wrongly, or used a mixed-up bit position, would latch on the wrong direction or on the wrong source. Targeted cases cover:
- a clear landing in the same cycle as an event, where a clear-wins design loses the event;
- a select write coinciding with a falling flag, where a design that applies the select early would raise a spurious event;
- a flag held high after its clear, where level-sensitive logic would set the bit again;
- reads of the reserved bit and of unmapped addresses, and cross-channel reads that would expose address-decode aliasing.

// File: rtl/lsi_pkg.sv
package lsi_pkg;
  localparam int OFS_W = 5;
  localparam logic [OFS_W-1:0] OFS_EDGE = 5'h15;
  localparam logic [OFS_W-1:0] OFS_PEND = 5'h16;
  localparam logic [OFS_W-1:0] OFS_MASK = 5'h17;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_EDGE = 2'd1,
    REG_PEND = 2'd2,
    REG_MASK = 2'd3
  } lsi_reg_e;

  function automatic lsi_reg_e reg_kind(input logic [OFS_W-1:0] ofs);
    case (ofs)
      OFS_EDGE: reg_kind = REG_EDGE;
      OFS_PEND: reg_kind = REG_PEND;
      OFS_MASK: reg_kind = REG_MASK;
      default:  reg_kind = REG_NONE;
    endcase
  endfunction
endpackage

// File: rtl/lsi_edge_detect.sv
module lsi_edge_detect #(
  parameter int N_SRC = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] flags,
  input  logic [N_SRC-1:0] both_edges,
  output logic [N_SRC-1:0] evt
);
  logic [N_SRC-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= flags;
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic rise, fall;
    assign rise   = flags[s] & ~prev_q[s];
    assign fall   = ~flags[s] & prev_q[s];
    assign evt[s] = rise | (both_edges[s] & fall);
  end
endmodule

// File: rtl/lsi_channel.sv
module lsi_channel #(
  parameter int N_SRC = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] flags,
  input  logic             wr_edge,
  input  logic             wr_pend,
  input  logic             wr_mask,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] edge_q,
  output logic [N_SRC-1:0] pend_q,
  output logic [N_SRC-1:0] mask_q,
  output logic             irq_q
);
  logic [N_SRC-1:0] evt;
  logic [N_SRC-1:0] pend_d;
  logic [N_SRC-1:0] mask_d;

  lsi_edge_detect #(.N_SRC(N_SRC)) u_det (
    .clk       (clk),
    .rst       (rst),
    .flags     (flags),
    .both_edges(edge_q),
    .evt       (evt)
  );

  always_comb begin
    pend_d = pend_q;
    if (wr_pend) pend_d = pend_d & ~wdata;
    pend_d = pend_d | evt;
    mask_d = wr_mask ? wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_q <= '0;
      pend_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_edge) edge_q <= wdata;
      pend_q <= pend_d;
      mask_q <= mask_d;
      irq_q  <= |(pend_d & mask_d);
    end
  end
endmodule

// File: rtl/line_status_irq.sv
module line_status_irq
  import lsi_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int NUM_SRC = 7,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  input  logic [NUM_CH*NUM_SRC-1:0]  status_in,
  output logic [NUM_CH-1:0]          irq_out
);
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CH_LSB = OFS_W;
  localparam int TOP_LSB = CH_LSB + CH_W;
  localparam int FLAT_W = NUM_CH * NUM_SRC;

  logic [FLAT_W-1:0] sel_all, pend_all, en_all;

  logic [CH_W-1:0] wr_ch, rd_ch;
  logic            wr_in_map, rd_in_map;
  lsi_reg_e        wr_kind, rd_kind;

  assign wr_ch     = wr_addr[CH_LSB +: CH_W];
  assign rd_ch     = rd_addr[CH_LSB +: CH_W];
  assign wr_in_map = ((wr_addr >> TOP_LSB) == '0) && (int'(wr_ch) < NUM_CH);
  assign rd_in_map = ((rd_addr >> TOP_LSB) == '0) && (int'(rd_ch) < NUM_CH);
  assign wr_kind   = wr_in_map ? reg_kind(wr_addr[OFS_W-1:0]) : REG_NONE;
  assign rd_kind   = rd_in_map ? reg_kind(rd_addr[OFS_W-1:0]) : REG_NONE;

  logic unused_wr_hi;
  assign unused_wr_hi = ^wr_data[DATA_W-1:NUM_SRC];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = wr_en && (wr_ch == CH_W'(c));

    lsi_channel #(.N_SRC(NUM_SRC)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .flags  (status_in[c*NUM_SRC +: NUM_SRC]),
      .wr_edge(hit && (wr_kind == REG_EDGE)),
      .wr_pend(hit && (wr_kind == REG_PEND)),
      .wr_mask(hit && (wr_kind == REG_MASK)),
      .wdata  (wr_data[NUM_SRC-1:0]),
      .edge_q (sel_all[c*NUM_SRC +: NUM_SRC]),
      .pend_q (pend_all[c*NUM_SRC +: NUM_SRC]),
      .mask_q (en_all[c*NUM_SRC +: NUM_SRC]),
      .irq_q  (irq_out[c])
    );
  end

  logic [NUM_SRC-1:0] rd_sel;
  always_comb begin
    rd_sel = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_ch == CH_W'(c)) begin
        case (rd_kind)
          REG_EDGE: rd_sel = sel_all[c*NUM_SRC +: NUM_SRC];
          REG_PEND: rd_sel = pend_all[c*NUM_SRC +: NUM_SRC];
          REG_MASK: rd_sel = en_all[c*NUM_SRC +: NUM_SRC];
          default:  rd_sel = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= {{(DATA_W-NUM_SRC){1'b0}}, rd_sel};
    else            rd_data <= '0;
  end
endmodule

// File: rtl/line_status_irq_chk.sv
module line_status_irq_chk #(
  parameter int NUM_CH  = 2,
  parameter int NUM_SRC = 7,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         wr_addr,
  input logic [DATA_W-1:0]         wr_data,
  input logic                      rd_en,
  input logic [ADDR_W-1:0]         rd_addr,
  input logic [DATA_W-1:0]         rd_data,
  input logic [NUM_CH*NUM_SRC-1:0] status_in,
  input logic [NUM_CH-1:0]         irq_out,
  input logic [NUM_CH*NUM_SRC-1:0] sel_all,
  input logic [NUM_CH*NUM_SRC-1:0] pend_all,
  input logic [NUM_CH*NUM_SRC-1:0] en_all
);
  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    is_mapped = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (a == ADDR_W'(c * 32 + 'h15) || a == ADDR_W'(c * 32 + 'h16) ||
          a == ADDR_W'(c * 32 + 'h17))
        is_mapped = 1'b1;
    end
  endfunction

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (irq_out == '0 && rd_data == '0 && pend_all == '0));

  assert_reserved_bits_zero_R3: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en) |-> (rd_data[DATA_W-1:NUM_SRC] == '0));

  assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && !is_mapped(rd_addr)) |-> (rd_data == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(c * 32 + 'h16);

    assert_irq_follows_mask_R8: assert property (@(posedge clk) disable iff (rst)
      irq_out[c] == |(pend_all[c*NUM_SRC +: NUM_SRC] & en_all[c*NUM_SRC +: NUM_SRC]));

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_s
      localparam int I = c * NUM_SRC + s;

      assert_rise_sets_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(status_in[I]) |=> pend_all[I]);

      assert_fall_sets_when_both_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(status_in[I]) && sel_all[I]) |=> pend_all[I]);

      assert_low_flag_no_event_R5: assert property (@(posedge clk) disable iff (rst)
        (!pend_all[I] && !sel_all[I] && !status_in[I]) |=> !pend_all[I]);

      assert_clear_only_by_write_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_all[I]) |-> $past(wr_en && wr_addr == PEND_A && wr_data[s]));
    end
  end
endmodule

bind line_status_irq line_status_irq_chk #(
  .NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .status_in(status_in),
  .irq_out(irq_out), .sel_all(sel_all), .pend_all(pend_all), .en_all(en_all)
);

// File: tb/tb_line_status_irq.sv
`timescale 1ns/1ps
module tb_line_status_irq;
  localparam int NCH = 2;
  localparam int NSRC = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [13:0] status_in = '0;
  logic [1:0]  irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  line_status_irq dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .status_in(status_in), .irq_out(irq_out)
  );

  function automatic logic [7:0] a_edge(input int c); return 8'(c * 32 + 'h15); endfunction
  function automatic logic [7:0] a_pend(input int c); return 8'(c * 32 + 'h16); endfunction
  function automatic logic [7:0] a_mask(input int c); return 8'(c * 32 + 'h17); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    tick();
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, {24'd0, d}, {24'd0, exp});
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq", {30'd0, irq_out}, 32'd0);
    chk("R1 rd_data idle", {24'd0, rd_data}, 32'd0);
    for (int c = 0; c < NCH; c++) begin
      rd_chk("R1 edge", a_edge(c), 8'h00);
      rd_chk("R1 pend", a_pend(c), 8'h00);
      rd_chk("R1 mask", a_mask(c), 8'h00);
    end

    // R2 / R10: register addressing and channel independence
    wr(a_edge(0), 8'h55);
    rd_chk("R2 edge ch0", a_edge(0), 8'h55);
    rd_chk("R10 edge ch1 untouched", a_edge(1), 8'h00);
    wr(a_mask(1), 8'h2A);
    rd_chk("R2 mask ch1", a_mask(1), 8'h2A);
    rd_chk("R10 mask ch0 untouched", a_mask(0), 8'h00);
    rd_chk("R2 read data lasts one cycle", 8'h00, 8'h00);
    chk("R2 idle rd_data zero", {24'd0, rd_data}, 32'd0);

    // R3: reserved bit
    wr(a_edge(1), 8'hFF);
    rd_chk("R3 edge bit7", a_edge(1), 8'h7F);
    wr(a_mask(0), 8'hFF);
    rd_chk("R3 mask bit7", a_mask(0), 8'h7F);

    // R10: unmapped reads
    rd_chk("R10 unmapped 14", 8'h14, 8'h00);
    rd_chk("R10 unmapped 18", 8'h18, 8'h00);
    rd_chk("R10 unmapped 55", 8'h55, 8'h00);
    rd_chk("R10 unmapped F6", 8'hF6, 8'h00);

    // R9: select writes with flags steady create no event
    rd_chk("R9 no event from select write", a_pend(0), 8'h00);
    rd_chk("R9 no event from select write ch1", a_pend(1), 8'h00);

    // Sweep: every channel, source and select value (R4, R5, R6, R7, R8, R11)
    for (int c = 0; c < NCH; c++) begin
      for (int s = 0; s < NSRC; s++) begin
        for (int m = 0; m < 2; m++) begin
          logic [7:0] bitv;
          bitv = 8'(1 << s);
          wr(a_edge(c), m[0] ? bitv : 8'h00);
          wr(a_mask(c), bitv);
          wr(a_edge(1 - c), 8'h00);
          wr(a_mask(1 - c), 8'h7F);
          status_in[c*NSRC + s] = 1'b1;
          tick();
          chk("R4 irq after rise", {31'd0, irq_out[c]}, 32'd1);
          chk("R10 other irq quiet", {31'd0, irq_out[1-c]}, 32'd0);
          rd_chk("R4 pend after rise", a_pend(c), bitv);
          rd_chk("R10 other pend quiet", a_pend(1 - c), 8'h00);
          wr(a_pend(c), bitv);
          chk("R7 irq drops on clear", {31'd0, irq_out[c]}, 32'd0);
          tick();
          rd_chk("R11 held flag no re-event", a_pend(c), 8'h00);
          status_in[c*NSRC + s] = 1'b0;
          tick();
          if (m == 0) begin
            rd_chk("R5 fall ignored", a_pend(c), 8'h00);
            chk("R5 irq stays low", {31'd0, irq_out[c]}, 32'd0);
          end else begin
            rd_chk("R6 fall latched", a_pend(c), bitv);
            chk("R6 irq on fall", {31'd0, irq_out[c]}, 32'd1);
          end
          wr(a_pend(c), 8'h7F);
        end
      end
    end
    wr(a_mask(0), 8'h00); wr(a_mask(1), 8'h00);
    wr(a_edge(0), 8'h00); wr(a_edge(1), 8'h00);

    // R8: disabled source still latches, enable raises irq on write edge
    status_in[1*NSRC + 3] = 1'b1;
    tick();
    chk("R8 masked irq low", {31'd0, irq_out[1]}, 32'd0);
    rd_chk("R8 masked pend latched", a_pend(1), 8'h08);
    wr(a_mask(1), 8'h08);
    chk("R8 irq after enable", {31'd0, irq_out[1]}, 32'd1);
    wr(a_mask(1), 8'h77);
    chk("R8 irq after disable", {31'd0, irq_out[1]}, 32'd0);
    status_in[1*NSRC + 3] = 1'b0;
    wr(a_mask(1), 8'h00);
    wr(a_pend(1), 8'h7F);
    rd_chk("R7 cleared", a_pend(1), 8'h00);

    // R7: event and clear in the same cycle, set wins
    status_in[0] = 1'b1;
    wr(a_pend(0), 8'h01);
    rd_chk("R7 set wins over clear", a_pend(0), 8'h01);
    wr(a_pend(0), 8'h00);
    rd_chk("R7 zero write keeps", a_pend(0), 8'h01);
    wr(a_pend(0), 8'h7E);
    rd_chk("R7 other-bit clear keeps", a_pend(0), 8'h01);
    wr(a_pend(0), 8'h01);
    rd_chk("R7 one clears", a_pend(0), 8'h00);
    status_in[0] = 1'b0;
    tick();

    // R9: select write in the same cycle as a falling flag uses old select
    status_in[1] = 1'b1;
    tick();
    wr(a_pend(0), 8'h7F);
    status_in[1] = 1'b0;
    wr(a_edge(0), 8'h02);
    rd_chk("R9 old select governs fall", a_pend(0), 8'h00);
    status_in[1] = 1'b1;
    tick();
    wr(a_pend(0), 8'h7F);
    status_in[1] = 1'b0;
    tick();
    rd_chk("R9 new select applies later", a_pend(0), 8'h02);
    wr(a_edge(0), 8'h00);
    wr(a_pend(0), 8'h7F);
    rd_chk("R9 final clear", a_pend(0), 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule